// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM with Flow-Through Reads

This block is a synthesizable behavioural model of a synchronous static RAM whose data bus can turn around between reads and writes with no idle cycle. A command (load or advance, read or write, chip selects, byte enables) is captured at one rising clock edge. The data transfer for that command happens in the cycle that follows. Read data is not registered on the way out: the stored word appears on `dout` during the data cycle. Write data on `din` is taken at the next enabled edge. Because the address phase of one command overlaps the data phase of the one before it, a stream of alternating reads and writes keeps the bus busy on every cycle.

A 2-bit burst counter lets one loaded address produce four data beats. Each beat is requested with an advance command, and the low two address bits follow either linear or interleaved order. A clock-enable input can freeze the whole device for as many cycles as needed. Three chip selects gate new commands without cutting off a transfer that is already pending. The bidirectional bus is split into `din`, `dout` and a drive-enable flag `dout_en`, and the flag is also gated asynchronously by an output enable.

The word is 36 bits wide, made of four 9-bit byte lanes. The storage array holds 2^ADDR_W words.

Top module: `zbt_ssram`

## Requirements
- R1: A read loaded at an enabled edge (cen_n=0, adv_ld=0, rw=1, chip selected) shows the stored word on dout with dout_en=1 during the cycle that immediately follows that edge.
- R2: A write loaded at an enabled edge (rw=0) stores din at the next enabled edge. Lane i, meaning bits 9*i+8 down to 9*i, is written only if bw_n[i] was 0 with the command. Lanes whose bw_n bit was 1 keep their old contents.
- R3: Reads and writes may alternate on consecutive cycles with no idle cycle between them. A read loaded right after a write to the same address returns the newly written data.
- R4: When burst_linear=1 at the load, each following advance (adv_ld=1) steps the low two address bits by +1, +2, +3 from the loaded address, modulo 4, and keeps the loaded operation type.
- R5: When burst_linear=0 at the load, the advances use the loaded low two address bits XORed with 1, 2 and 3.
- R6: The upper address bits never change during a burst, and a fifth beat wraps the counter back to the loaded address.
- R7: While cen_n=1, every other synchronous input is ignored and all internal state holds. A read being output stays on dout, and a write awaiting its data is completed at the next enabled edge with the din present then.
- R8: The device is selected only when ce1_n=0, ce2=1 and ce3_n=0. A load without selection starts nothing, so dout_en is 0 in the next cycle. An advance after such a deselect does nothing, and a write pending from the previous command still completes.
- R9: dout_en is 0 in the cycle after a write is loaded and in the cycle after a deselecting load.
- R10: oe_n=1 forces dout_en to 0 immediately, with no clock edge, and has no effect on any stored state.
- R11: After synchronous reset (rst=1 at a clock edge), dout_en is 0 and no burst is active, so an advance issued first performs no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high stalls the device |
| adv_ld | input | 1 | 0 loads a new command and address, 1 advances the burst |
| rw | input | 1 | 1 read, 0 write; used on a load |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| burst_linear | input | 1 | Burst order captured at load: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address for a load |
| bw_n | input | 4 | Byte-lane write enables, active low, one per 9-bit lane |
| din | input | 36 | Write data, taken in the data cycle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Read data, flow-through from the array |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The hardest situation to reach from the ports is a write whose data cycle is split by a stall or by a deselecting command. In that case the word must be taken from whatever din holds at the next enabled edge, and not at the stalled edge. The stimulus loads a write and then holds cen_n high with a decoy value on din. It then releases the stall with a different value and reads the address back. A second case loads a write and follows it at once with an unselected load, which shows that the pending data phase survives a deselect.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [LANES-1:0] lane_en;
    } cmd_t;

    // Low address bits for beat number step of a burst that started at start.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] step,
                                               input logic       linear);
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              adv_ld,
    input  logic              rw,
    input  logic              chip_sel,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    output cmd_t              issue_cmd,
    output logic [ADDR_W-1:0] issue_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nxt;
    op_e               op_q;
    logic              active_q;
    logic              lin_q;

    assign cnt_nxt = cnt_q + 2'd1;

    always_comb begin
        issue_cmd.lane_en = ~bw_n;
        if (!adv_ld) begin
            issue_cmd.valid = chip_sel;
            issue_cmd.op    = rw ? OP_READ : OP_WRITE;
            issue_addr      = addr;
        end else begin
            issue_cmd.valid = active_q;
            issue_cmd.op    = op_q;
            issue_addr      = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_nxt, lin_q)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= 2'd0;
            op_q     <= OP_READ;
            active_q <= 1'b0;
            lin_q    <= 1'b1;
        end else if (!cen_n) begin
            if (!adv_ld) begin
                base_q   <= addr;
                cnt_q    <= 2'd0;
                op_q     <= rw ? OP_READ : OP_WRITE;
                active_q <= chip_sel;
                lin_q    <= linear;
            end else if (active_q) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R6
    burst_upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_ld && active_q) |-> (issue_addr[ADDR_W-1:2] == base_q[ADDR_W-1:2]));

    // R6
    load_restarts_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld) |=> (cnt_q == 2'd0));

endmodule

// File: rtl/zbt_data_path.sv
module zbt_data_path
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  cmd_t              issue_cmd,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [WORD_W-1:0] din,
    input  logic              oe_n,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    localparam int DEPTH = 1 << ADDR_W;

    cmd_t              stg_q;
    logic [ADDR_W-1:0] stg_addr_q;
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q      <= '0;
            stg_addr_q <= '0;
        end else if (!cen_n) begin
            stg_q      <= issue_cmd;
            stg_addr_q <= issue_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !cen_n && stg_q.valid && stg_q.op == OP_WRITE) begin
            for (int l = 0; l < LANES; l++) begin
                if (stg_q.lane_en[l]) begin
                    mem[stg_addr_q][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign dout    = mem[stg_addr_q];
    assign dout_en = stg_q.valid && (stg_q.op == OP_READ) && !oe_n;

    // R7
    stall_holds_stage_chk: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(stg_q) && $stable(stg_addr_q)));

endmodule

// File: rtl/zbt_ssram.sv
module zbt_ssram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              adv_ld,
    input  logic              rw,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              burst_linear,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        bw_n,
    input  logic [35:0]       din,
    input  logic              oe_n,
    output logic [35:0]       dout,
    output logic              dout_en
);

    logic              chip_sel;
    cmd_t              issue_cmd;
    logic [ADDR_W-1:0] issue_addr;

    assign chip_sel = !ce1_n && ce2 && !ce3_n;

    zbt_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cen_n      (cen_n),
        .adv_ld     (adv_ld),
        .rw         (rw),
        .chip_sel   (chip_sel),
        .linear     (burst_linear),
        .addr       (addr),
        .bw_n       (bw_n),
        .issue_cmd  (issue_cmd),
        .issue_addr (issue_addr)
    );

    zbt_data_path #(.ADDR_W(ADDR_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .cen_n      (cen_n),
        .issue_cmd  (issue_cmd),
        .issue_addr (issue_addr),
        .din        (din),
        .oe_n       (oe_n),
        .dout       (dout),
        .dout_en    (dout_en)
    );

    // R8
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && !chip_sel) |=> !dout_en);

    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && chip_sel && !rw) |=> !dout_en);

endmodule

// File: tb/sim_zbt_ssram.sv
`timescale 1ns/1ps
module sim_zbt_ssram;

    logic        clk = 1'b0;
    logic        rst, cen_n, adv_ld, rw, ce1_n, ce2, ce3_n, burst_linear, oe_n;
    logic [5:0]  addr;
    logic [3:0]  bw_n;
    logic [35:0] din, dout;
    logic        dout_en;

    logic [35:0] ref_mem [64];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    zbt_ssram #(.ADDR_W(6)) u0 (
        .clk(clk), .rst(rst), .cen_n(cen_n), .adv_ld(adv_ld), .rw(rw),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .burst_linear(burst_linear),
        .addr(addr), .bw_n(bw_n), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk36(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ld(input logic r, input logic [5:0] a, input logic [3:0] b);
        cen_n = 0; adv_ld = 0; rw = r; addr = a; bw_n = b;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic adv();
        cen_n = 0; adv_ld = 1; bw_n = 4'h0;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic nop();
        cen_n = 0; adv_ld = 0; rw = 1; ce1_n = 0; ce2 = 0; ce3_n = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [35:0] d);
        ld(0, a, 4'h0); tick();
        din = d; nop(); tick();
        ref_mem[a] = d;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a);
        ld(1, a, 4'h0); tick();
        chk36(req, dout, ref_mem[a]);
        chk1(req, dout_en, 1'b1);
    endtask

    function automatic logic [5:0] beat(input logic [5:0] base, input int k, input logic lin);
        logic [1:0] s;
        s = 2'(k);
        return {base[5:2], lin ? (base[1:0] + s) : (base[1:0] ^ s)};
    endfunction

    task automatic t_reset();
        chk1("R11 reset", dout_en, 1'b0);
        adv(); tick();
        chk1("R11 advance after reset", dout_en, 1'b0);
        nop(); tick();
    endtask

    task automatic t_basic();
        wr(6'd5, 36'h1_2345_6789);
        rd_chk("R1 read after load", 6'd5);
        wr(6'd6, 36'hA_AAAA_AAAA);
        ld(0, 6'd6, 4'b1010); tick();
        din = 36'h5_5555_5555; nop(); tick();
        for (int l = 0; l < 4; l++)
            if (l == 0 || l == 2) ref_mem[6][l*9 +: 9] = din[l*9 +: 9];
        rd_chk("R2 byte lanes", 6'd6);
        nop(); tick();
    endtask

    task automatic t_turnaround();
        ld(0, 6'd7, 4'h0); tick();
        din = 36'h7_7777_0007; ld(1, 6'd5, 4'h0); tick();
        ref_mem[7] = 36'h7_7777_0007;
        chk36("R3 read after write cycle", dout, ref_mem[5]);
        chk1("R3 read enable", dout_en, 1'b1);
        ld(0, 6'd8, 4'h0); tick();
        chk1("R9 write cycle quiet", dout_en, 1'b0);
        din = 36'h8_8888_0008; ld(1, 6'd7, 4'h0); tick();
        ref_mem[8] = 36'h8_8888_0008;
        chk36("R3 same address after write", dout, 36'h7_7777_0007);
        ld(1, 6'd8, 4'h0); tick();
        chk36("R3 back to back read", dout, 36'h8_8888_0008);
        nop(); tick();
        chk1("R9 deselect quiet", dout_en, 1'b0);
    endtask

    task automatic t_burst();
        burst_linear = 1;
        ld(0, 6'd16, 4'h0); tick();
        for (int k = 0; k < 4; k++) begin
            din = 36'h1_0000_0010 + 36'(k);
            if (k < 3) adv(); else nop();
            tick();
            ref_mem[beat(6'd16, k, 1'b1)] = 36'h1_0000_0010 + 36'(k);
        end
        ld(0, 6'd22, 4'h0); tick();
        for (int k = 0; k < 4; k++) begin
            din = 36'h2_0000_0020 + 36'(k);
            if (k < 3) adv(); else nop();
            tick();
            ref_mem[beat(6'd22, k, 1'b1)] = 36'h2_0000_0020 + 36'(k);
        end
        rd_chk("R4 linear write burst", 6'd20);
        nop(); tick();
        ld(1, 6'd17, 4'h0); tick();
        for (int k = 1; k < 5; k++) begin
            adv(); tick();
            chk36("R4 linear read beat", dout, ref_mem[beat(6'd17, k, 1'b1)]);
        end
        chk36("R6 wrap to start", dout, ref_mem[17]);
        burst_linear = 0;
        ld(1, 6'd17, 4'h0); tick();
        burst_linear = 1;
        for (int k = 1; k < 4; k++) begin
            adv(); tick();
            chk36("R5 interleaved beat", dout, ref_mem[beat(6'd17, k, 1'b0)]);
            chk1("R5 enable", dout_en, 1'b1);
        end
        nop(); tick();
    endtask

    task automatic t_stall();
        ld(1, 6'd5, 4'h0); tick();
        cen_n = 1; adv_ld = 0; rw = 0; addr = 6'd7; tick();
        chk36("R7 stalled read held", dout, ref_mem[5]);
        chk1("R7 stalled enable", dout_en, 1'b1);
        ld(0, 6'd9, 4'h0); tick();
        cen_n = 1; din = 36'hD_EAD0_0001; tick();
        chk1("R7 stalled write quiet", dout_en, 1'b0);
        din = 36'h9_9999_0009; nop(); tick();
        ref_mem[9] = 36'h9_9999_0009;
        rd_chk("R7 deferred write data", 6'd9);
        ld(1, 6'd16, 4'h0); tick();
        adv(); tick();
        cen_n = 1; tick();
        adv(); tick();
        chk36("R7 burst resumes after stall", dout, ref_mem[18]);
        nop(); tick();
    endtask

    task automatic t_select();
        for (int k = 0; k < 3; k++) begin
            ld(1, 6'd5, 4'h0);
            if (k == 0) ce1_n = 1;
            if (k == 1) ce2 = 0;
            if (k == 2) ce3_n = 1;
            tick();
            chk1("R8 single select off", dout_en, 1'b0);
        end
        ld(0, 6'd10, 4'h0); tick();
        din = 36'hB_0B0B_0B0B; ld(1, 6'd5, 4'h0); ce3_n = 1; tick();
        ref_mem[10] = 36'hB_0B0B_0B0B;
        chk1("R8 deselected read", dout_en, 1'b0);
        adv(); tick();
        chk1("R8 advance after deselect", dout_en, 1'b0);
        rd_chk("R8 pending write completed", 6'd10);
        nop(); tick();
    endtask

    task automatic t_oe();
        ld(1, 6'd5, 4'h0); tick();
        oe_n = 1; #1;
        chk1("R10 async disable", dout_en, 1'b0);
        oe_n = 0; #1;
        chk1("R10 re-enable", dout_en, 1'b1);
        chk36("R10 data intact", dout, ref_mem[5]);
        nop(); tick();
    endtask

    initial begin
        rst = 1; cen_n = 0; adv_ld = 0; rw = 1; ce1_n = 0; ce2 = 0; ce3_n = 0;
        burst_linear = 1; addr = '0; bw_n = '0; din = '0; oe_n = 0;
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        tick(); tick();
        rst = 0;
        t_reset();
        t_basic();
        t_turnaround();
        t_burst();
        t_stall();
        t_select();
        t_oe();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule